// File: doc/BRIEF.md
# Switch Memory Interleave Port Decoder

This block sits on the upstream side of a virtual switch and chooses which downstream virtual bridge receives each transaction from the root port. It handles three classes of traffic, and each class has its own routing rule. Memory requests are matched against programmed address windows and spread across 2, 4 or 8 downstream ports. The port is chosen from the address bits just above a programmable interleave granularity. I/O requests are matched against per-port inclusive base/limit windows, in the manner of a bridge. Cache requests do not go through address decode. They go directly to the one port that software has enabled for caching. Their payload is forwarded unchanged, because the switch never interprets coherence messages.

Each result carries a port index, a hit flag, an error flag, the class, and the untouched payload. Decode is combinational and is followed by one register stage, so one result comes out every cycle. Responses from downstream devices return toward the root port through a second registered path. Software programs the block through a plain register write port.

Top module: `sw_port_decoder`

## Requirements
- R1: Every request cycle (`req_valid_i`=1) produces exactly one result on the next clock edge, and the class and payload are copied unchanged. A cycle without a request gives `out_valid_o`=0, and hit, err, port, class and data are all zero.
- R2: Memory window w is enabled by bit 0 of its control register. It matches when base <= address <= limit, with both bounds inclusive. The window registers sit at 0x10+4w (base), 0x11+4w (limit) and 0x12+4w (control). When windows overlap, the lowest-numbered matching window wins.
- R3: The control register has three interleave fields. Bits [2:1] hold the way code k: codes 1, 2 and 3 give 2, 4 and 8 ways, and code 0 gives a single target. Bits [5:3] hold the granularity code g: codes 0 to 6 give 256 B << g, and code 7 acts as code 6. Bits [8:6] hold the first port F. The target port is (F + ((address >> (8+g)) mod 2^k)) mod 8.
- R4: A memory request that matches no window reports hit=0, err=0 and port=0. Hit and err are never both set.
- R5: Downstream port p has an I/O window with base at register 0x40+2p and limit at 0x41+2p. The window is off whenever limit < base, and matches inclusively otherwise. The lowest matching port wins. When no window matches, the result is hit=0, err=0, port=0.
- R6: A cache-class request (class code 1) goes to the port held in bits [3:1] of register 0x00, provided bit 0 of that register is set. The address is ignored.
- R7: A cache-class request that arrives while no caching port is enabled reports err=1, hit=0, port=0. Reserved class code 3 also reports err=1. Class codes: 0 is I/O, 1 is cache, 2 is memory.
- R8: A downstream response (`dn_rsp_valid_i`) appears on the upstream response outputs one cycle later, with its data and source port unchanged. A cycle without a response drives all of those outputs to zero.
- R9: After reset every memory window and the caching port are disabled, and every I/O window has base all ones and limit zero. As a result, no request hits.
- R10: A register write is applied at the clock edge that accepts it. A request in the same cycle is decoded with the old settings, and a request in the next cycle sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| req_valid_i | input | 1 | Upstream request valid |
| req_class_i | input | 2 | Protocol class (0 I/O, 1 cache, 2 memory, 3 reserved) |
| req_addr_i | input | 32 | Request address |
| req_data_i | input | DATA_W | Request payload |
| out_valid_o | output | 1 | Decode result valid |
| out_class_o | output | 2 | Class of the decoded request |
| out_port_o | output | 3 | Selected downstream port |
| out_hit_o | output | 1 | A target was found |
| out_err_o | output | 1 | Cache request with no caching port enabled, or reserved class |
| out_data_o | output | DATA_W | Forwarded payload |
| dn_rsp_valid_i | input | 1 | Downstream response valid |
| dn_rsp_port_i | input | 3 | Port the response came from |
| dn_rsp_data_i | input | DATA_W | Response payload |
| up_rsp_valid_o | output | 1 | Response valid toward the root port |
| up_rsp_port_o | output | 3 | Source port of the response |
| up_rsp_data_o | output | DATA_W | Response payload toward the root port |

## Verification
Each decode result is due on the first rising edge after the request is presented, and each upstream response is due on the first rising edge after the downstream response arrives. Nothing else sits in the path. The bench drives inputs on the falling edge and predicts the result from the register contents as they stood before that rising edge. It applies any write from the same cycle to its model only after the edge, which exercises R10. It then compares all outputs on the next falling edge, every cycle, idle cycles included.

// File: rtl/sw_dec_pkg.sv
package sw_dec_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned PORT_W = 3;
  localparam int unsigned NUM_PORTS = 1 << PORT_W;

  typedef enum logic [1:0] {
    CLS_IO    = 2'd0,
    CLS_CACHE = 2'd1,
    CLS_MEM   = 2'd2,
    CLS_RSVD  = 2'd3
  } cls_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic              en;
    logic [1:0]        ways_log;
    logic [2:0]        gran;
    logic [PORT_W-1:0] first;
  } mem_win_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
  } io_win_t;

  typedef struct packed {
    logic              en;
    logic [PORT_W-1:0] port;
  } cache_cfg_t;
endpackage

// File: rtl/sw_dec_cfg.sv
module sw_dec_cfg
  import sw_dec_pkg::*;
#(
  parameter int unsigned NUM_MEM_WIN = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [7:0]                        addr_i,
  input  logic [ADDR_W-1:0]                 wdata_i,
  output mem_win_t [NUM_MEM_WIN-1:0]        mem_o,
  output io_win_t  [NUM_PORTS-1:0]          io_o,
  output cache_cfg_t                        cache_o
);
  localparam int unsigned MEM_BASE_IDX = 16;
  localparam int unsigned IO_BASE_IDX  = 64;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cache_o <= '0;
      for (int w = 0; w < int'(NUM_MEM_WIN); w++) mem_o[w] <= '0;
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
        io_o[p].base  <= '1;
        io_o[p].limit <= '0;
      end
    end else if (we_i) begin
      if (addr_i == 8'h00) begin
        cache_o.en   <= wdata_i[0];
        cache_o.port <= wdata_i[PORT_W:1];
      end
      for (int w = 0; w < int'(NUM_MEM_WIN); w++) begin
        if (addr_i == 8'(MEM_BASE_IDX + 4*w))     mem_o[w].base  <= wdata_i;
        if (addr_i == 8'(MEM_BASE_IDX + 4*w + 1)) mem_o[w].limit <= wdata_i;
        if (addr_i == 8'(MEM_BASE_IDX + 4*w + 2)) begin
          mem_o[w].en       <= wdata_i[0];
          mem_o[w].ways_log <= wdata_i[2:1];
          mem_o[w].gran     <= wdata_i[5:3];
          mem_o[w].first    <= wdata_i[6 +: PORT_W];
        end
      end
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
        if (addr_i == 8'(IO_BASE_IDX + 2*p))     io_o[p].base  <= wdata_i;
        if (addr_i == 8'(IO_BASE_IDX + 2*p + 1)) io_o[p].limit <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/sw_dec_mem.sv
module sw_dec_mem
  import sw_dec_pkg::*;
#(
  parameter int unsigned NUM_MEM_WIN = 2
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  mem_win_t [NUM_MEM_WIN-1:0] win_i,
  output logic                       hit_o,
  output logic [PORT_W-1:0]          port_o
);
  localparam int unsigned GRAN_BASE = 8;

  logic [NUM_MEM_WIN-1:0] hit_w;
  logic [PORT_W-1:0]      port_w [NUM_MEM_WIN];

  for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_win
    logic [2:0]        gran_c;
    logic [4:0]        shift;
    logic [ADDR_W-1:0] shifted;
    logic [3:0]        mask;
    logic [2:0]        idx;
    always_comb begin
      hit_w[w] = win_i[w].en && (addr_i >= win_i[w].base) && (addr_i <= win_i[w].limit);
      gran_c   = (win_i[w].gran == 3'd7) ? 3'd6 : win_i[w].gran;
      shift    = 5'(GRAN_BASE) + {2'b00, gran_c};
      shifted  = addr_i >> shift;
      mask     = (4'd1 << win_i[w].ways_log) - 4'd1;
      idx      = shifted[2:0] & mask[2:0];
      port_w[w] = win_i[w].first + PORT_W'(idx);
    end
  end

  always_comb begin
    hit_o  = 1'b0;
    port_o = '0;
    for (int w = int'(NUM_MEM_WIN) - 1; w >= 0; w--) begin
      if (hit_w[w]) begin
        hit_o  = 1'b1;
        port_o = port_w[w];
      end
    end
  end
endmodule

// File: rtl/sw_dec_io.sv
module sw_dec_io
  import sw_dec_pkg::*;
(
  input  logic [ADDR_W-1:0]       addr_i,
  input  io_win_t [NUM_PORTS-1:0] win_i,
  output logic                    hit_o,
  output logic [PORT_W-1:0]       port_o
);
  logic [NUM_PORTS-1:0] hit_p;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign hit_p[p] = (win_i[p].base <= win_i[p].limit) &&
                      (addr_i >= win_i[p].base) && (addr_i <= win_i[p].limit);
  end

  always_comb begin
    hit_o  = 1'b0;
    port_o = '0;
    for (int p = int'(NUM_PORTS) - 1; p >= 0; p--) begin
      if (hit_p[p]) begin
        hit_o  = 1'b1;
        port_o = PORT_W'(p);
      end
    end
  end
endmodule

// File: rtl/sw_port_decoder.sv
module sw_port_decoder
  import sw_dec_pkg::*;
#(
  parameter int unsigned NUM_MEM_WIN = 2,
  parameter int unsigned DATA_W      = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_class_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              out_valid_o,
  output logic [1:0]        out_class_o,
  output logic [PORT_W-1:0] out_port_o,
  output logic              out_hit_o,
  output logic              out_err_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              dn_rsp_valid_i,
  input  logic [PORT_W-1:0] dn_rsp_port_i,
  input  logic [DATA_W-1:0] dn_rsp_data_i,
  output logic              up_rsp_valid_o,
  output logic [PORT_W-1:0] up_rsp_port_o,
  output logic [DATA_W-1:0] up_rsp_data_o
);
  mem_win_t [NUM_MEM_WIN-1:0] mem_cfg;
  io_win_t  [NUM_PORTS-1:0]   io_cfg;
  cache_cfg_t                 cache_cfg;

  logic              mem_hit, io_hit;
  logic [PORT_W-1:0] mem_port, io_port;
  logic              hit_d, err_d;
  logic [PORT_W-1:0] port_d;

  sw_dec_cfg #(.NUM_MEM_WIN(NUM_MEM_WIN)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .mem_o   (mem_cfg),
    .io_o    (io_cfg),
    .cache_o (cache_cfg)
  );

  sw_dec_mem #(.NUM_MEM_WIN(NUM_MEM_WIN)) u_mem (
    .addr_i (req_addr_i),
    .win_i  (mem_cfg),
    .hit_o  (mem_hit),
    .port_o (mem_port)
  );

  sw_dec_io u_io (
    .addr_i (req_addr_i),
    .win_i  (io_cfg),
    .hit_o  (io_hit),
    .port_o (io_port)
  );

  always_comb begin
    hit_d  = 1'b0;
    err_d  = 1'b0;
    port_d = '0;
    case (cls_e'(req_class_i))
      CLS_MEM: begin
        hit_d  = mem_hit;
        port_d = mem_hit ? mem_port : '0;
      end
      CLS_IO: begin
        hit_d  = io_hit;
        port_d = io_hit ? io_port : '0;
      end
      CLS_CACHE: begin
        // no address decode: single caching port per hierarchy
        if (cache_cfg.en) begin
          hit_d  = 1'b1;
          port_d = cache_cfg.port;
        end else begin
          err_d = 1'b1;
        end
      end
      default: err_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_class_o <= '0;
      out_port_o  <= '0;
      out_hit_o   <= 1'b0;
      out_err_o   <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= req_valid_i;
      out_class_o <= req_valid_i ? req_class_i : '0;
      out_port_o  <= req_valid_i ? port_d : '0;
      out_hit_o   <= req_valid_i & hit_d;
      out_err_o   <= req_valid_i & err_d;
      out_data_o  <= req_valid_i ? req_data_i : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_rsp_valid_o <= 1'b0;
      up_rsp_port_o  <= '0;
      up_rsp_data_o  <= '0;
    end else begin
      up_rsp_valid_o <= dn_rsp_valid_i;
      up_rsp_port_o  <= dn_rsp_valid_i ? dn_rsp_port_i : '0;
      up_rsp_data_o  <= dn_rsp_valid_i ? dn_rsp_data_i : '0;
    end
  end
endmodule

// File: rtl/sw_dec_chk.sv
module sw_dec_chk
  import sw_dec_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_class_i,
  input logic [DATA_W-1:0] req_data_i,
  input logic              out_valid_o,
  input logic [1:0]        out_class_o,
  input logic [PORT_W-1:0] out_port_o,
  input logic              out_hit_o,
  input logic              out_err_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              dn_rsp_valid_i,
  input logic [PORT_W-1:0] dn_rsp_port_i,
  input logic [DATA_W-1:0] dn_rsp_data_i,
  input logic              up_rsp_valid_o,
  input logic [PORT_W-1:0] up_rsp_port_o,
  input logic [DATA_W-1:0] up_rsp_data_o,
  input logic              cache_en_i,
  input logic [PORT_W-1:0] cache_port_i
);
  assert_req_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> out_valid_o && out_data_o == $past(req_data_i) &&
                    out_class_o == $past(req_class_i));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !out_valid_o && !out_hit_o && !out_err_o);

  assert_hit_err_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_hit_o && out_err_o));

  assert_miss_port_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_hit_o) |-> out_port_o == '0);

  assert_cache_route_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_class_i == 2'd1 && cache_en_i) |=>
      out_hit_o && out_port_o == $past(cache_port_i));

  assert_cache_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ((req_class_i == 2'd1 && !cache_en_i) || req_class_i == 2'd3)) |=>
      out_err_o && !out_hit_o);

  assert_rsp_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_rsp_valid_i |=> up_rsp_valid_o && up_rsp_data_o == $past(dn_rsp_data_i) &&
                       up_rsp_port_o == $past(dn_rsp_port_i));
endmodule

bind sw_port_decoder sw_dec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_class_i    (req_class_i),
  .req_data_i     (req_data_i),
  .out_valid_o    (out_valid_o),
  .out_class_o    (out_class_o),
  .out_port_o     (out_port_o),
  .out_hit_o      (out_hit_o),
  .out_err_o      (out_err_o),
  .out_data_o     (out_data_o),
  .dn_rsp_valid_i (dn_rsp_valid_i),
  .dn_rsp_port_i  (dn_rsp_port_i),
  .dn_rsp_data_i  (dn_rsp_data_i),
  .up_rsp_valid_o (up_rsp_valid_o),
  .up_rsp_port_o  (up_rsp_port_o),
  .up_rsp_data_o  (up_rsp_data_o),
  .cache_en_i     (cache_cfg.en),
  .cache_port_i   (cache_cfg.port)
);

// File: tb/sw_port_decoder_tb.sv
`timescale 1ns/1ps
module sw_port_decoder_tb;
  localparam int DW = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [7:0]    cfg_addr_i = '0;
  logic [31:0]   cfg_wdata_i = '0;
  logic          req_valid_i = 1'b0;
  logic [1:0]    req_class_i = '0;
  logic [31:0]   req_addr_i = '0;
  logic [DW-1:0] req_data_i = '0;
  logic          out_valid_o, out_hit_o, out_err_o;
  logic [1:0]    out_class_o;
  logic [2:0]    out_port_o;
  logic [DW-1:0] out_data_o;
  logic          dn_rsp_valid_i = 1'b0;
  logic [2:0]    dn_rsp_port_i = '0;
  logic [DW-1:0] dn_rsp_data_i = '0;
  logic          up_rsp_valid_o;
  logic [2:0]    up_rsp_port_o;
  logic [DW-1:0] up_rsp_data_o;

  sw_port_decoder #(.NUM_MEM_WIN(2), .DATA_W(DW)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference configuration
  logic [31:0] m_base [2];
  logic [31:0] m_lim  [2];
  bit          m_en   [2];
  int          m_ways [2];
  int          m_gran [2];
  int          m_first[2];
  logic [31:0] io_base[8];
  logic [31:0] io_lim [8];
  bit          c_en;
  int          c_port;

  function automatic void model_reset();
    for (int w = 0; w < 2; w++) begin
      m_base[w] = '0; m_lim[w] = '0; m_en[w] = 0; m_ways[w] = 0; m_gran[w] = 0; m_first[w] = 0;
    end
    for (int p = 0; p < 8; p++) begin
      io_base[p] = 32'hFFFF_FFFF; io_lim[p] = '0;
    end
    c_en = 0; c_port = 0;
  endfunction

  function automatic void model_write(logic [7:0] a, logic [31:0] d);
    if (a == 8'h00) begin c_en = d[0]; c_port = int'(d[3:1]); end
    for (int w = 0; w < 2; w++) begin
      if (a == 8'(16 + 4*w)) m_base[w] = d;
      if (a == 8'(17 + 4*w)) m_lim[w] = d;
      if (a == 8'(18 + 4*w)) begin
        m_en[w] = d[0]; m_ways[w] = int'(d[2:1]); m_gran[w] = int'(d[5:3]); m_first[w] = int'(d[8:6]);
      end
    end
    for (int p = 0; p < 8; p++) begin
      if (a == 8'(64 + 2*p)) io_base[p] = d;
      if (a == 8'(65 + 2*p)) io_lim[p] = d;
    end
  endfunction

  function automatic logic [31:0] ctrl(bit en, int ways, int gran, int first);
    return {23'd0, 3'(first), 3'(gran), 2'(ways), en};
  endfunction

  // expected {hit, err, port}
  function automatic void model_decode(int cls, logic [31:0] a, output bit hit, output bit err, output int port);
    hit = 0; err = 0; port = 0;
    if (cls == 2) begin
      for (int w = 0; w < 2; w++) begin
        if (!hit && m_en[w] && a >= m_base[w] && a <= m_lim[w]) begin
          int g = (m_gran[w] == 7) ? 6 : m_gran[w];
          longint unsigned blk = longint'(a) / (longint'(256) << g);
          int idx = int'(blk % (longint'(1) << m_ways[w]));
          hit = 1; port = (m_first[w] + idx) % 8;
        end
      end
    end else if (cls == 0) begin
      for (int p = 0; p < 8; p++) begin
        if (!hit && io_base[p] <= io_lim[p] && a >= io_base[p] && a <= io_lim[p]) begin
          hit = 1; port = p;
        end
      end
    end else if (cls == 1) begin
      if (c_en) begin hit = 1; port = c_port; end else err = 1;
    end else begin
      err = 1;
    end
  endfunction

  task automatic step(string tag, bit v, int cls, logic [31:0] a, logic [DW-1:0] d,
                      bit we, logic [7:0] wa, logic [31:0] wd,
                      bit rv, int rp, logic [DW-1:0] rd);
    bit eh, ee; int ep;
    logic [DW-1:0] exp_rd;
    req_valid_i = v; req_class_i = 2'(cls); req_addr_i = a; req_data_i = d;
    cfg_we_i = we; cfg_addr_i = wa; cfg_wdata_i = wd;
    dn_rsp_valid_i = rv; dn_rsp_port_i = 3'(rp); dn_rsp_data_i = rd;
    model_decode(cls, a, eh, ee, ep);
    if (!v) begin eh = 0; ee = 0; ep = 0; end
    exp_rd = rv ? rd : '0;
    @(posedge clk_i);
    if (we) model_write(wa, wd);
    @(negedge clk_i);
    vectors++;
    if (out_valid_o !== v || out_hit_o !== eh || out_err_o !== ee || out_port_o !== 3'(ep) ||
        out_class_o !== (v ? 2'(cls) : 2'd0) || out_data_o !== (v ? d : '0)) begin
      fails++;
      $display("FAIL %s: req got v=%0b hit=%0b err=%0b port=%0d cls=%0d data=%h exp v=%0b hit=%0b err=%0b port=%0d cls=%0d data=%h",
               tag, out_valid_o, out_hit_o, out_err_o, out_port_o, out_class_o, out_data_o,
               v, eh, ee, ep, v ? cls : 0, v ? d : '0);
    end
    vectors++;
    if (up_rsp_valid_o !== rv || up_rsp_port_o !== (rv ? 3'(rp) : 3'd0) || up_rsp_data_o !== exp_rd) begin
      fails++;
      $display("FAIL %s: rsp got v=%0b port=%0d data=%h exp v=%0b port=%0d data=%h",
               tag, up_rsp_valid_o, up_rsp_port_o, up_rsp_data_o, rv, rv ? rp : 0, exp_rd);
    end
  endtask

  task automatic req(string tag, int cls, logic [31:0] a);
    step(tag, 1, cls, a, {a, 32'hC0DE_0000 | a[15:0]}, 0, 8'h0, 32'h0, 0, 0, '0);
  endtask

  task automatic wr(string tag, logic [7:0] wa, logic [31:0] wd);
    step(tag, 0, 0, 32'h0, '0, 1, wa, wd, 0, 0, '0);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 reset state and nothing hits
    step("R9_idle", 0, 0, 32'h0, '0, 0, 8'h0, 32'h0, 0, 0, '0);
    req("R9_mem_miss", 2, 32'h0);
    req("R9_io_miss", 0, 32'h0);
    req("R9_io_miss_ones", 0, 32'hFFFF_FFFF);
    req("R7_cache_disabled", 1, 32'h1234);
    req("R7_reserved_class", 3, 32'h1234);

    // R10 write and request same cycle: old config used
    step("R10_same_cycle", 1, 1, 32'h40, 64'hAB, 1, 8'h00, 32'h0000_000B, 0, 0, '0);
    req("R6_cache_port5", 1, 32'h40);
    req("R6_cache_addr_ignored", 1, 32'hDEAD_BEEF);

    // memory windows
    wr("R2_cfg", 8'h10, 32'h1000_0000);
    wr("R2_cfg", 8'h11, 32'h1FFF_FFFF);
    wr("R3_cfg", 8'h12, ctrl(1, 2, 0, 2));
    wr("R2_cfg", 8'h14, 32'h1800_0000);
    wr("R2_cfg", 8'h15, 32'h2FFF_FFFF);
    wr("R3_cfg", 8'h16, ctrl(1, 3, 6, 0));
    for (int i = 0; i < 6; i++) req("R3_four_way_256", 2, 32'h1000_0000 + 32'(i * 256 + 17));
    req("R2_base_inclusive", 2, 32'h1000_0000);
    req("R2_limit_inclusive", 2, 32'h1FFF_FFFF);
    req("R2_overlap_low_wins", 2, 32'h1800_0100);
    for (int i = 0; i < 9; i++) req("R3_eight_way_16k", 2, 32'h2000_0000 + 32'(i * 16384));
    req("R4_mem_miss_below", 2, 32'h0FFF_FFFF);
    req("R4_mem_miss_above", 2, 32'h3000_0000);
    wr("R3_cfg", 8'h16, ctrl(1, 1, 7, 5));
    for (int i = 0; i < 4; i++) req("R3_gran7_as_6", 2, 32'h2000_0000 + 32'(i * 16384));
    wr("R3_cfg", 8'h16, ctrl(1, 0, 2, 7));
    for (int i = 0; i < 3; i++) req("R3_single_way", 2, 32'h2100_0000 + 32'(i * 1024));
    wr("R2_cfg", 8'h12, ctrl(0, 2, 0, 2));
    req("R2_disabled_window", 2, 32'h1000_0100);

    // I/O windows
    wr("R5_cfg", 8'h46, 32'h0000_0100);
    wr("R5_cfg", 8'h47, 32'h0000_01FF);
    wr("R5_cfg", 8'h42, 32'h0000_0180);
    wr("R5_cfg", 8'h43, 32'h0000_02FF);
    wr("R5_cfg", 8'h4C, 32'h0000_0600);
    wr("R5_cfg", 8'h4D, 32'h0000_0500);
    req("R5_io_port3", 0, 32'h0000_0100);
    req("R5_io_overlap_low_wins", 0, 32'h0000_0190);
    req("R5_io_limit_incl", 0, 32'h0000_02FF);
    req("R5_io_miss", 0, 32'h0000_0300);
    req("R5_io_disabled_limit_lt_base", 0, 32'h0000_0580);
    req("R5_mem_class_no_io", 2, 32'h0000_0100);

    // R8 responses alongside requests
    for (int i = 0; i < 8; i++)
      step("R8_rsp", i[0], 0, 32'h0000_0150, 64'(i), 0, 8'h0, 32'h0, 1, i, {32'hFACE_0000, 32'(i)});

    // R1 back-to-back mixed traffic
    for (int i = 0; i < 400; i++) begin
      int cls = int'($urandom_range(0, 3));
      logic [31:0] a = (cls == 0) ? 32'($urandom_range(0, 32'h0000_0700))
                                  : 32'h0F00_0000 + 32'($urandom_range(0, 32'h2200_0000));
      bit v = ($urandom_range(0, 4) != 0);
      bit rv = $urandom_range(0, 1) == 1;
      step("R1_stream", v, cls, a, {$urandom, $urandom}, 0, 8'h0, 32'h0,
           rv, int'($urandom_range(0, 7)), {$urandom, $urandom});
    end
    wr("R7_cfg", 8'h00, 32'h0);
    req("R7_cache_disabled_again", 1, 32'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule